// File: doc/BRIEF.md
# NAND Host Bus Bridge

This block connects a host bus that uses byte-wide control registers and a 16-bit data port to the 8-bit pin interface of a NAND flash device. The host writes a control byte that drives the chip-enable, command-latch and address-latch lines, the card power switch, the write-protect line and a two-bit ECC mode selector. Writes to the data port then become strobed byte cycles on the flash pins. A 16-bit access becomes two byte cycles in a fixed order, and an 8-bit write becomes exactly one byte cycle, so command and address bytes can be sent one at a time. A status register reports the flash ready/busy line.

Host requests enter on a valid/ready channel. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. The block lowers `req_ready` while a flash byte sequence is running or while a read response waits to be taken. A request presented during that time is held by the host and accepted later, never dropped. Read data leaves on a second valid/ready channel. `rsp_valid` and `rsp_data` stay unchanged until `rsp_ready` is sampled high. The write strobe and read strobe stay low for `PULSE_CLKS` clocks. Each byte cycle starts with a `SETUP_CLKS` clock phase in which the latch lines and the output data are already stable.

Top module: `nand_host_bridge`

## Requirements
- R1: After reset the control byte is 0x00. The outputs are then: chip enable off (`nand_ce_n`=1), `nand_cle`=0, `nand_ale`=0, both strobes high, `nand_dq_oe`=0, power off, `req_ready`=1 and `rsp_valid`=0.
- R2: The control byte sits at offset 4 and reads back in bits 7:0 with bits 15:8 zero. Its bits drive the outputs from the clock edge that accepts the write:
  - bit0 drives `nand_cle`.
  - bit1 drives `nand_ale`.
  - bit2 drives `nand_pwr_en`.
  - bit4 set drives `nand_ce_n` low.
  - bits 6:5 drive `ecc_mode`.
  - bit7 drives `nand_wp_n`.
- R3: A read at offset 5 returns 0x80 while `nand_rb_n` is low (busy) and 0x00 while it is high. The line passes through a two-flop synchronizer, so a change shows within three clocks.
- R4: A 16-bit write at offset 0 produces two write-strobe pulses. The first carries bits 7:0 and the second carries bits 15:8.
- R5: An 8-bit write at offset 0 produces exactly one write-strobe pulse, carrying bits 7:0.
- R6: A 16-bit read at offset 0 performs two read-strobe cycles and places the first byte in bits 7:0 and the second in bits 15:8. An 8-bit read performs one cycle and returns the byte in bits 7:0 with bits 15:8 zero.
- R7: Every byte cycle of a data-port write carries the `nand_cle` and `nand_ale` levels set by the current control byte (bit0, bit1).
- R8: Each strobe stays low for exactly `PULSE_CLKS` clocks. The two strobes are never low together. `nand_cle`, `nand_ale` and `nand_dq_out` do not change in the clock before a write strobe falls.
- R9: `req_ready` is low while a flash byte sequence is in progress. A request held through that time is accepted afterwards and carried out in order.
- R10: `rsp_valid` and `rsp_data` hold until `rsp_ready` is sampled high. No new request is accepted while a response is pending.
- R11: A register read response is visible right after the accepting edge. A data read response is visible `SETUP_CLKS+PULSE_CLKS+1` edges per byte after the accepting edge.
- R12: Offsets other than 0, 4 and 5 read as zero, and writes to them change no output and start no flash cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_addr | input | 3 | Byte offset of the register |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 16 | Read response data |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_pwr_en | output | 1 | Card power switch |
| nand_dq_out | output | 8 | Byte driven onto the flash data pins |
| nand_dq_oe | output | 1 | Output enable for the flash data pins |
| nand_dq_in | input | 8 | Byte read from the flash data pins |
| nand_rb_n | input | 1 | Flash ready (1) / busy (0) |
| ecc_mode | output | 2 | ECC mode selector from the control byte |

## Verification
The bench counts edges from the accepting edge of each request. It expects a register read response right after that edge and a data read response after `SETUP_CLKS+PULSE_CLKS+1` edges per byte, and it compares the counted latency exactly. Control-byte outputs are sampled on the falling edge after the accepting edge. Status changes are read only after three clocks, to cover the two synchronizer stages. A pin monitor samples on every falling edge. It measures each strobe's low time, checks latch and data stability at the fall, and logs each written byte at the rise of its strobe. Write results are compared only after `req_ready` returns high, which marks the end of the whole sequence.

// File: rtl/nhb_pkg.sv
package nhb_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd5;

  localparam int CB_CLE = 0;
  localparam int CB_ALE = 1;
  localparam int CB_PWR = 2;
  localparam int CB_CE  = 4;
  localparam int CB_ECC_LO = 5;
  localparam int CB_WP  = 7;

  typedef enum logic [1:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD
  } phase_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_FIRST, SQ_SECOND
  } seq_e;
endpackage

// File: rtl/nhb_regs.sv
module nhb_regs
  import nhb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_byte,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  input  logic              rb_n_async,
  output logic [7:0]        ctrl_q
);
  logic rb_meta, rb_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= 8'h00;
      rb_meta <= 1'b1;
      rb_sync <= 1'b1;
    end else begin
      rb_meta <= rb_n_async;
      rb_sync <= rb_meta;
      if (wr_en && wr_addr == OFS_CTRL) ctrl_q <= wr_byte;
    end
  end

  always_comb begin
    unique case (rd_addr)
      OFS_CTRL: rd_byte = ctrl_q;
      OFS_STAT: rd_byte = {~rb_sync, 7'b0};
      default:  rd_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/nhb_byte_engine.sv
module nhb_byte_engine
  import nhb_pkg::*;
#(
  parameter int SETUP_CLKS = 1,
  parameter int PULSE_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_read,
  input  logic [7:0] start_byte,
  output logic       done,
  output logic [7:0] rd_byte,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] dq_out,
  output logic       dq_oe,
  input  logic [7:0] dq_in
);
  localparam int LONGEST = (SETUP_CLKS > PULSE_CLKS) ? SETUP_CLKS : PULSE_CLKS;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CLKS - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_q;
  logic [7:0]       byte_q;
  logic [7:0]       cap_q;
  logic             can_start;

  assign can_start = (ph_q == PH_IDLE) || (ph_q == PH_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      byte_q <= 8'h00;
      cap_q  <= 8'h00;
    end else begin
      unique case (ph_q)
        PH_SETUP: begin
          if (cnt_q == '0) begin
            ph_q  <= PH_STROBE;
            cnt_q <= PULSE_LAST;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt_q == '0) begin
            ph_q <= PH_HOLD;
            if (rd_q) cap_q <= dq_in;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD:  ph_q <= PH_IDLE;
        default:  ph_q <= PH_IDLE;
      endcase
      if (start && can_start) begin
        ph_q   <= PH_SETUP;
        cnt_q  <= SETUP_LAST;
        rd_q   <= start_read;
        byte_q <= start_byte;
      end
    end
  end

  assign done    = (ph_q == PH_HOLD);
  assign rd_byte = cap_q;
  assign we_n    = !((ph_q == PH_STROBE) && !rd_q);
  assign re_n    = !((ph_q == PH_STROBE) && rd_q);
  assign dq_out  = byte_q;
  assign dq_oe   = (ph_q != PH_IDLE) && !rd_q;
endmodule

// File: rtl/nhb_sequencer.sv
module nhb_sequencer
  import nhb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_data,
  output logic              reg_wr,
  input  logic [7:0]        reg_rd_byte,
  output logic              eng_start,
  output logic              eng_read,
  output logic [7:0]        eng_byte,
  input  logic              eng_done,
  input  logic [7:0]        eng_rd_byte
);
  seq_e        sq_q;
  logic        two_q, rd_q, rsp_v_q;
  logic [7:0]  hi_q, lo_q;
  logic [15:0] rsp_d_q;
  logic        accept, is_data, more;

  assign req_ready = (sq_q == SQ_IDLE) && !rsp_v_q;
  assign accept    = req_valid && req_ready;
  assign is_data   = (req_addr == OFS_DATA);
  assign reg_wr    = accept && req_write && !is_data;
  assign more      = (sq_q == SQ_FIRST) && eng_done && two_q;

  assign eng_start = (accept && is_data) || more;
  assign eng_read  = accept ? !req_write : rd_q;
  assign eng_byte  = accept ? req_wdata[7:0] : hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_q    <= SQ_IDLE;
      two_q   <= 1'b0;
      rd_q    <= 1'b0;
      hi_q    <= 8'h00;
      lo_q    <= 8'h00;
      rsp_v_q <= 1'b0;
      rsp_d_q <= 16'h0000;
    end else begin
      if (rsp_v_q && rsp_ready) rsp_v_q <= 1'b0;
      unique case (sq_q)
        SQ_IDLE: begin
          if (accept && is_data) begin
            sq_q  <= SQ_FIRST;
            two_q <= req_wide;
            rd_q  <= !req_write;
            hi_q  <= req_wdata[15:8];
          end else if (accept && !req_write) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= {8'h00, reg_rd_byte};
          end
        end
        SQ_FIRST: begin
          if (eng_done) begin
            if (two_q) begin
              sq_q <= SQ_SECOND;
              lo_q <= eng_rd_byte;
            end else begin
              sq_q <= SQ_IDLE;
              if (rd_q) begin
                rsp_v_q <= 1'b1;
                rsp_d_q <= {8'h00, eng_rd_byte};
              end
            end
          end
        end
        SQ_SECOND: begin
          if (eng_done) begin
            sq_q <= SQ_IDLE;
            if (rd_q) begin
              rsp_v_q <= 1'b1;
              rsp_d_q <= {eng_rd_byte, lo_q};
            end
          end
        end
        default: sq_q <= SQ_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_d_q;
endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge
  import nhb_pkg::*;
#(
  parameter int SETUP_CLKS = 1,
  parameter int PULSE_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_wide,
  input  logic [2:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [15:0] rsp_data,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic        nand_wp_n,
  output logic        nand_pwr_en,
  output logic [7:0]  nand_dq_out,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_in,
  input  logic        nand_rb_n,
  output logic [1:0]  ecc_mode
);
  logic [7:0] ctrl_q, reg_rd_byte, eng_byte, eng_rd_byte;
  logic       reg_wr, eng_start, eng_read, eng_done;

  nhb_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_addr(req_addr), .wr_byte(req_wdata[7:0]),
    .rd_addr(req_addr), .rd_byte(reg_rd_byte),
    .rb_n_async(nand_rb_n), .ctrl_q(ctrl_q)
  );

  nhb_sequencer u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .reg_wr(reg_wr), .reg_rd_byte(reg_rd_byte),
    .eng_start(eng_start), .eng_read(eng_read), .eng_byte(eng_byte),
    .eng_done(eng_done), .eng_rd_byte(eng_rd_byte)
  );

  nhb_byte_engine #(.SETUP_CLKS(SETUP_CLKS), .PULSE_CLKS(PULSE_CLKS)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(eng_start), .start_read(eng_read), .start_byte(eng_byte),
    .done(eng_done), .rd_byte(eng_rd_byte),
    .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_out(nand_dq_out), .dq_oe(nand_dq_oe), .dq_in(nand_dq_in)
  );

  assign nand_cle    = ctrl_q[CB_CLE];
  assign nand_ale    = ctrl_q[CB_ALE];
  assign nand_pwr_en = ctrl_q[CB_PWR];
  assign nand_ce_n   = ~ctrl_q[CB_CE];
  assign ecc_mode    = ctrl_q[CB_ECC_LO+1:CB_ECC_LO];
  assign nand_wp_n   = ctrl_q[CB_WP];
endmodule

// File: rtl/nhb_checker.sv
module nhb_checker #(
  parameter int PULSE_CLKS = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_data,
  input logic        nand_we_n,
  input logic        nand_re_n,
  input logic        nand_cle,
  input logic        nand_ale,
  input logic [7:0]  nand_dq_out,
  input logic        nand_dq_oe
);
  localparam int LW = $clog2(PULSE_CLKS + 1) + 1;
  logic [LW-1:0] low_len;
  logic          strobe;

  assign strobe = !nand_we_n || !nand_re_n;

  always_ff @(posedge clk) begin
    if (!rst_n) low_len <= '0;
    else if (strobe) low_len <= low_len + 1'b1;
    else low_len <= '0;
  end

  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  a_r8_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && low_len != '0) |-> (low_len == LW'(PULSE_CLKS)));

  a_r8_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_dq_out)));

  a_r9_no_accept_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !req_ready);

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r10_no_accept_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && req_valid) |-> !req_ready);

  a_r4_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  a_r6_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);
endmodule

bind nand_host_bridge nhb_checker #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_cle(nand_cle),
  .nand_ale(nand_ale), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe)
);

// File: tb/sim_nand_host_bridge.sv
`timescale 1ns/1ps
module sim_nand_host_bridge;
  localparam int SETUP = 1;
  localparam int PULSE = 2;
  localparam int BYTE_LAT = SETUP + PULSE + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, rsp_ready = 1'b0;
  logic [2:0] req_addr = 3'd0;
  logic [15:0] req_wdata = 16'h0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic ce_n, cle, ale, we_n, re_n, wp_n, pwr, dq_oe, rb_n = 1'b1;
  logic [7:0] dq_out, dq_in;
  logic [1:0] ecc;

  int checks = 0, errors = 0;
  int rd_idx = 0;
  logic [9:0] wlog [0:7];
  int wcnt = 0;
  int low_len = 0;
  logic prev_we = 1'b1, prev_re = 1'b1, prev_cle = 1'b0, prev_ale = 1'b0;
  logic [7:0] prev_dq = 8'h0;
  logic [15:0] got;
  int lat;
  logic [7:0] exp_mode = 8'h00;

  always #10 clk = ~clk;

  assign dq_in = 8'hA0 + 8'(rd_idx);

  nand_host_bridge #(.SETUP_CLKS(SETUP), .PULSE_CLKS(PULSE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale),
    .nand_we_n(we_n), .nand_re_n(re_n), .nand_wp_n(wp_n), .nand_pwr_en(pwr),
    .nand_dq_out(dq_out), .nand_dq_oe(dq_oe), .nand_dq_in(dq_in),
    .nand_rb_n(rb_n), .ecc_mode(ecc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Flash pin monitor: strobe width, setup stability, byte log, read pattern
  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n && prev_we)
        chk(cle == prev_cle && ale == prev_ale && dq_out == prev_dq, "R8 setup",
            {cle, ale, dq_out}, {prev_cle, prev_ale, prev_dq});
      if (!we_n || !re_n) low_len++;
      if (we_n && !prev_we) begin
        if (wcnt < 8) wlog[wcnt] = {prev_cle, prev_ale, prev_dq};
        wcnt++;
        chk(low_len == PULSE, "R8 write pulse", low_len, PULSE);
        low_len = 0;
      end
      if (re_n && !prev_re) begin
        rd_idx++;
        chk(low_len == PULSE, "R8 read pulse", low_len, PULSE);
        low_len = 0;
      end
      prev_we = we_n; prev_re = re_n; prev_cle = cle; prev_ale = ale; prev_dq = dq_out;
    end
  end

  task automatic host_op(input bit wr, input bit wide, input logic [2:0] a,
                         input logic [15:0] d, input bit nowait);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      lat = 0;
      while (!rsp_valid) begin @(negedge clk); lat++; end
      got = rsp_data;
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
    end else if (!nowait) begin
      while (!req_ready) @(negedge clk);
    end
  endtask

  task automatic chk_pins(input string req);
    chk({ce_n, cle, ale, pwr, wp_n, ecc} ==
        {~exp_mode[4], exp_mode[0], exp_mode[1], exp_mode[2], exp_mode[7], exp_mode[6:5]},
        req, {ce_n, cle, ale, pwr, wp_n, ecc},
        {~exp_mode[4], exp_mode[0], exp_mode[1], exp_mode[2], exp_mode[7], exp_mode[6:5]});
  endtask

  typedef struct packed {
    logic wr; logic wide; logic [2:0] ofs; logic [15:0] dat; logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{1'b1, 1'b0, 3'd4, 16'h0095, 16'h0000},
    '{1'b1, 1'b0, 3'd0, 16'h0090, 16'h0090},
    '{1'b1, 1'b0, 3'd4, 16'h0096, 16'h0000},
    '{1'b1, 1'b1, 3'd0, 16'h3412, 16'h3412},
    '{1'b1, 1'b0, 3'd4, 16'h0094, 16'h0000},
    '{1'b0, 1'b1, 3'd0, 16'h0000, 16'hA1A0},
    '{1'b0, 1'b0, 3'd0, 16'h0000, 16'h00A2},
    '{1'b1, 1'b1, 3'd0, 16'hBEEF, 16'hBEEF},
    '{1'b0, 1'b0, 3'd4, 16'h0000, 16'h0094},
    '{1'b1, 1'b0, 3'd6, 16'h00FF, 16'h0000},
    '{1'b0, 1'b0, 3'd4, 16'h0000, 16'h0094},
    '{1'b0, 1'b0, 3'd7, 16'h0000, 16'h0000},
    '{1'b1, 1'b0, 3'd4, 16'h0074, 16'h0000},
    '{1'b0, 1'b0, 3'd4, 16'h0000, 16'h0074},
    '{1'b1, 1'b0, 3'd4, 16'h0000, 16'h0000},
    '{1'b0, 1'b0, 3'd4, 16'h0000, 16'h0000}
  };

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL R9 watchdog: actual=hung expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({ce_n, cle, ale, we_n, re_n, dq_oe, pwr, req_ready, rsp_valid} == 9'b1_0_0_1_1_0_0_1_0,
        "R1 reset outputs", {ce_n, cle, ale, we_n, re_n, dq_oe, pwr, req_ready, rsp_valid},
        9'b1_0_0_1_1_0_0_1_0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      vec_t v;
      v = VEC[i];
      wcnt = 0;
      host_op(v.wr, v.wide, v.ofs, v.dat, 1'b0);
      if (v.wr) begin
        if (v.ofs == 3'd4) begin
          exp_mode = v.dat[7:0];
          chk_pins("R2 control outputs");
        end else if (v.ofs == 3'd0) begin
          chk(wcnt == (v.wide ? 2 : 1), v.wide ? "R4 byte count" : "R5 byte count",
              wcnt, v.wide ? 2 : 1);
          chk(wlog[0] == {exp_mode[0], exp_mode[1], v.exp[7:0]}, "R7 first byte",
              wlog[0], {exp_mode[0], exp_mode[1], v.exp[7:0]});
          if (v.wide)
            chk(wlog[1] == {exp_mode[0], exp_mode[1], v.exp[15:8]}, "R4 second byte",
                wlog[1], {exp_mode[0], exp_mode[1], v.exp[15:8]});
        end else begin
          chk(wcnt == 0, "R12 no flash cycle", wcnt, 0);
          chk_pins("R12 outputs unchanged");
        end
      end else begin
        chk(got == v.exp, v.ofs == 3'd0 ? "R6 read data" : (v.ofs == 3'd4 ? "R2 readback" : "R12 read zero"),
            got, v.exp);
        chk(lat == (v.ofs == 3'd0 ? (v.wide ? 2 : 1) * BYTE_LAT : 0), "R11 latency",
            lat, v.ofs == 3'd0 ? (v.wide ? 2 : 1) * BYTE_LAT : 0);
      end
    end

    // R3: status reflects busy line after synchronizer
    rb_n = 1'b0;
    repeat (3) @(negedge clk);
    host_op(1'b0, 1'b0, 3'd5, 16'h0, 1'b0);
    chk(got == 16'h0080, "R3 busy", got, 16'h0080);
    rb_n = 1'b1;
    repeat (3) @(negedge clk);
    host_op(1'b0, 1'b0, 3'd5, 16'h0, 1'b0);
    chk(got == 16'h0000, "R3 ready", got, 16'h0000);

    // R9: stall while a byte sequence runs, then held request proceeds in order
    host_op(1'b1, 1'b0, 3'd4, 16'h0094, 1'b0);
    exp_mode = 8'h94;
    wcnt = 0;
    host_op(1'b1, 1'b0, 3'd0, 16'h005A, 1'b1);
    chk(req_ready == 1'b0, "R9 stall during cycle", req_ready, 0);
    host_op(1'b1, 1'b1, 3'd0, 16'hC3B2, 1'b0);
    chk(wcnt == 3, "R9 no request lost", wcnt, 3);
    chk({wlog[0][7:0], wlog[1][7:0], wlog[2][7:0]} == 24'h5AB2C3, "R9 order",
        {wlog[0][7:0], wlog[1][7:0], wlog[2][7:0]}, 24'h5AB2C3);

    // R10: response held under back-pressure, new request refused meanwhile
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_wide = 1'b0; req_addr = 3'd4;
    @(posedge clk);
    @(negedge clk);
    req_addr = 3'd7;
    got = rsp_data;
    repeat (3) @(negedge clk);
    chk(rsp_valid && rsp_data == got && got == 16'h0094, "R10 response held",
        {rsp_valid, rsp_data}, {1'b1, 16'h0094});
    chk(req_ready == 1'b0, "R10 no accept while pending", req_ready, 0);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R10 released",
        {rsp_valid, req_ready}, 2'b01);

    // R1: reset returns control byte to standby
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_mode = 8'h00;
    chk_pins("R1 reset control");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule